// File: doc/BRIEF.md
# Diagnostic Sense Multiplexer with Thermal Fault Flag

This block decides what a dual-channel power driver puts on its single shared diagnostic sense line. When sensing is switched on, a two-bit select picks one of four sources: the scaled load current of channel 0, the scaled load current of channel 1, the die temperature, or the supply voltage. When sensing is switched off, the line is released to high impedance, so several drivers can share one sense resistor and one converter input. The output is a registered data word together with a registered drive-enable.

A current reading is replaced by a fixed fault code (the all-ones word) when its own channel has a thermal event (power limitation or thermal shutdown). It is also replaced when that channel is commanded off and an open load is detected. Each channel keeps a fault flag with hysteresis. A thermal event sets the flag. The flag clears only once the channel's hot-spot temperature falls below a fault-reset threshold, which sits below the automatic-restart threshold. As a result, the indication stays steady while the channel cycles through shutdown and restart. A channel that reports a negative output condition releases the line while its current is selected.

Top module: `diag_sense_mux`

## Requirements
- R1: While `sense_en` is sampled low at a clock edge, `sense_drive` is 0 and `sense_data` is 0 after that edge, whatever the other inputs are.
- R2: With `sense_en` high, the select code sampled at an edge picks the source shown after that edge: 2'b00 channel 0 current, 2'b01 channel 1 current, 2'b10 `temp_in`, 2'b11 `vsup_in`, with `sense_drive` at 1.
- R3: A current reading equals the channel's `cur_in` shifted right by log2(`SENSE_RATIO`). A result that would reach or exceed the all-ones code is clamped to all-ones minus one, so a reading never imitates the fault code.
- R4: A thermal event on a channel makes that channel's current selection show the all-ones fault code with `sense_drive` 1 after the same edge. A thermal event on the other channel has no effect on the reading.
- R5: Temperature and supply selections show their input values unchanged while either channel has a thermal event or a held fault flag.
- R6: Once set, a channel's fault flag holds while its `hot_temp` is at or above `FAULT_CLR_TEMP`. If `hot_temp` is first sampled below that threshold with no event, the fault code still shows after that edge, and the current reading returns at the second edge.
- R7: With `ch_on` low and `open_load` high on a channel, that channel's current selection shows the all-ones code. With `ch_on` high, `open_load` is ignored.
- R8: `neg_out` high on the selected current channel forces `sense_drive` to 0 and `sense_data` to 0, and this takes priority over any fault code.
- R9: While `rst_n` is low, `sense_drive` and `sense_data` are 0 and both fault flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_en | input | 1 | Sense line enable; low releases the line |
| sense_sel | input | 2 | Source select (00 ch0, 01 ch1, 10 temperature, 11 supply) |
| cur_in | input | 2x16 | Digitized output current per channel |
| temp_in | input | 12 | Digitized die temperature code |
| vsup_in | input | 12 | Digitized supply voltage code |
| therm_evt | input | 2 | Per-channel thermal event (power limitation or shutdown) |
| hot_temp | input | 2x8 | Per-channel hot-spot temperature code |
| ch_on | input | 2 | Per-channel drive command |
| open_load | input | 2 | Per-channel off-state open-load detect |
| neg_out | input | 2 | Per-channel negative output condition |
| sense_data | output | 12 | Registered sense word |
| sense_drive | output | 1 | Registered drive-enable for the sense line |

## Verification
Every selection, override and release takes effect one clock edge after the inputs are sampled. The exception is the clearing of a held fault flag, which shows one edge later than the sample that drops the hot-spot temperature. The bench drives inputs on the falling edge and updates its own model at the rising edge from the inputs just sampled. It then compares both outputs at the next falling edge, so every expected value lines up with the edge that produced it. The hysteresis case walks the temperature down cycle by cycle, and the fault code must persist exactly through the first below-threshold edge.

// File: rtl/dsm_pkg.sv
// Package: shared select and per-channel view encodings for the sense multiplexer.
// Assumes a dual-channel driver; select codes are fixed by the pin decode.
package dsm_pkg;
    typedef enum logic [1:0] {
        SEL_CUR0 = 2'b00,
        SEL_CUR1 = 2'b01,
        SEL_TEMP = 2'b10,
        SEL_VSUP = 2'b11
    } sense_sel_e;

    typedef enum logic [1:0] {
        VIEW_HIZ   = 2'b00,
        VIEW_FAULT = 2'b01,
        VIEW_VALUE = 2'b10
    } view_kind_e;
endpackage

// File: rtl/dsm_fault_hold.sv
// Module: per-channel fault flag with clear hysteresis.
// A thermal event sets the flag. The flag clears only when the hot-spot
// temperature is sampled below CLR_TEMP with no event. fault_now merges the
// live event with the held flag. Assumes a synchronous active-low reset.
module dsm_fault_hold #(
    parameter int unsigned TW       = 8,
    parameter int unsigned CLR_TEMP = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          therm_evt,
    input  logic [TW-1:0] hot_temp,
    output logic          flag_q,
    output logic          fault_now
);
    localparam logic [TW-1:0] CLR_CODE = TW'(CLR_TEMP);

    // Purpose: hold the flag while the hot spot stays at or above the clear threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= therm_evt | (flag_q & (hot_temp >= CLR_CODE));
    end

    // Purpose: fault seen by the reading this cycle.
    always_comb fault_now = therm_evt | flag_q;
endmodule

// File: rtl/dsm_chan_view.sv
// Module: forms what one channel's current selection would show.
// It scales current by a power-of-two sense ratio and clamps below the fault
// code. Its priority is negative output (release) over fault code over value.
// Assumes CUR_W >= DW.
module dsm_chan_view
    import dsm_pkg::*;
#(
    parameter int unsigned CUR_W = 16,
    parameter int unsigned DW    = 12,
    parameter int unsigned KSH   = 4
) (
    input  logic [CUR_W-1:0] cur,
    input  logic             fault_now,
    input  logic             ch_on,
    input  logic             open_load,
    input  logic             neg_out,
    output view_kind_e       kind,
    output logic [DW-1:0]    value
);
    localparam logic [CUR_W-1:0] CAP = CUR_W'((64'd1 << DW) - 64'd1);

    logic [CUR_W-1:0] shifted;

    // Purpose: divide by the sense ratio and keep the result off the fault code.
    always_comb begin
        shifted = cur >> KSH;
        if (shifted >= CAP) value = DW'(CAP - 1'b1);
        else                value = DW'(shifted);
    end

    // Purpose: decide the view kind for this channel.
    always_comb begin
        if (neg_out)                        kind = VIEW_HIZ;
        else if (fault_now)                 kind = VIEW_FAULT;
        else if (!ch_on && open_load)       kind = VIEW_FAULT;
        else                                kind = VIEW_VALUE;
    end
endmodule

// File: rtl/diag_sense_mux.sv
// Module: top of the diagnostic sense multiplexer.
// It selects among the channel currents, temperature and supply, overrides a
// current reading with the all-ones fault code, and registers data and
// drive-enable together. Assumes a dual-channel driver and a power-of-two
// SENSE_RATIO.
module diag_sense_mux
    import dsm_pkg::*;
#(
    parameter int unsigned CUR_W          = 16,
    parameter int unsigned DW             = 12,
    parameter int unsigned TW             = 8,
    parameter int unsigned SENSE_RATIO    = 16,
    parameter int unsigned FAULT_CLR_TEMP = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sense_en,
    input  logic [1:0]           sense_sel,
    input  logic [1:0][CUR_W-1:0] cur_in,
    input  logic [DW-1:0]        temp_in,
    input  logic [DW-1:0]        vsup_in,
    input  logic [1:0]           therm_evt,
    input  logic [1:0][TW-1:0]   hot_temp,
    input  logic [1:0]           ch_on,
    input  logic [1:0]           open_load,
    input  logic [1:0]           neg_out,
    output logic [DW-1:0]        sense_data,
    output logic                 sense_drive
);
    localparam int unsigned NCH = 2;
    localparam int unsigned KSH = $clog2(SENSE_RATIO);
    localparam logic [DW-1:0] FAULT_CODE = '1;

    logic [NCH-1:0]         fault_flag;
    logic [NCH-1:0]         fault_now;
    view_kind_e             kind   [NCH];
    logic [DW-1:0]          value  [NCH];
    logic                   nxt_drive;
    logic [DW-1:0]          nxt_data;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsm_fault_hold #(.TW(TW), .CLR_TEMP(FAULT_CLR_TEMP)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .therm_evt (therm_evt[c]),
            .hot_temp  (hot_temp[c]),
            .flag_q    (fault_flag[c]),
            .fault_now (fault_now[c])
        );

        dsm_chan_view #(.CUR_W(CUR_W), .DW(DW), .KSH(KSH)) u_view (
            .cur       (cur_in[c]),
            .fault_now (fault_now[c]),
            .ch_on     (ch_on[c]),
            .open_load (open_load[c]),
            .neg_out   (neg_out[c]),
            .kind      (kind[c]),
            .value     (value[c])
        );
    end

    // Purpose: choose the next word and drive-enable from enable and select.
    always_comb begin
        nxt_drive = 1'b0;
        nxt_data  = '0;
        if (sense_en) begin
            unique case (sense_sel_e'(sense_sel))
                SEL_TEMP: begin nxt_drive = 1'b1; nxt_data = temp_in; end
                SEL_VSUP: begin nxt_drive = 1'b1; nxt_data = vsup_in; end
                default: begin
                    unique case (kind[sense_sel[0]])
                        VIEW_FAULT: begin nxt_drive = 1'b1; nxt_data = FAULT_CODE; end
                        VIEW_VALUE: begin nxt_drive = 1'b1; nxt_data = value[sense_sel[0]]; end
                        default:    begin nxt_drive = 1'b0; nxt_data = '0; end
                    endcase
                end
            endcase
        end
    end

    // Purpose: register data and drive-enable in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_drive <= 1'b0;
            sense_data  <= '0;
        end else begin
            sense_drive <= nxt_drive;
            sense_data  <= nxt_data;
        end
    end
endmodule

// File: rtl/dsm_checks.sv
// Module: assertion checker for diag_sense_mux, attached by bind.
// Assumes the top's default channel count of two.
module dsm_checks #(
    parameter int unsigned CUR_W          = 16,
    parameter int unsigned DW             = 12,
    parameter int unsigned TW             = 8,
    parameter int unsigned FAULT_CLR_TEMP = 100
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sense_en,
    input logic [1:0]            sense_sel,
    input logic [DW-1:0]         temp_in,
    input logic [1:0]            therm_evt,
    input logic [1:0][TW-1:0]    hot_temp,
    input logic [1:0]            neg_out,
    input logic [1:0]            fault_flag,
    input logic [DW-1:0]         sense_data,
    input logic                  sense_drive
);
    localparam logic [TW-1:0] CLR_CODE = TW'(FAULT_CLR_TEMP);

    // R1
    en_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_en |=> !sense_drive);

    // R4
    evt_fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && sense_sel == 2'b00 && therm_evt[0] && !neg_out[0])
        |=> (sense_drive && sense_data == '1));

    // R5
    temp_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && sense_sel == 2'b10) |=> (sense_drive && sense_data == $past(temp_in)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag[0] && hot_temp[0] >= CLR_CODE) |=> fault_flag[0]);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!therm_evt[0] && hot_temp[0] < CLR_CODE) |=> !fault_flag[0]);

    // R8
    neg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && sense_sel == 2'b01 && neg_out[1]) |=> !sense_drive);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_drive |-> sense_data == '0);
endmodule

bind diag_sense_mux dsm_checks #(
    .CUR_W(CUR_W), .DW(DW), .TW(TW), .FAULT_CLR_TEMP(FAULT_CLR_TEMP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sense_en    (sense_en),
    .sense_sel   (sense_sel),
    .temp_in     (temp_in),
    .therm_evt   (therm_evt),
    .hot_temp    (hot_temp),
    .neg_out     (neg_out),
    .fault_flag  (fault_flag),
    .sense_data  (sense_data),
    .sense_drive (sense_drive)
);

// File: tb/sim_diag_sense_mux.sv
`timescale 1ns/1ps
module sim_diag_sense_mux;
    localparam int CW = 16;
    localparam int DW = 12;
    localparam int TW = 8;
    localparam int KSH = 4;
    localparam int CLR = 100;
    localparam int ALL1 = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_en = 1'b0;
    logic [1:0] sense_sel = 2'b00;
    logic [1:0][CW-1:0] cur_in = '0;
    logic [DW-1:0] temp_in = '0;
    logic [DW-1:0] vsup_in = '0;
    logic [1:0] therm_evt = '0;
    logic [1:0][TW-1:0] hot_temp = '0;
    logic [1:0] ch_on = 2'b11;
    logic [1:0] open_load = '0;
    logic [1:0] neg_out = '0;
    logic [DW-1:0] sense_data;
    logic sense_drive;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int mflag [2] = '{0, 0};
    int exp_drive = 0;
    int exp_data = 0;

    always #4 clk = ~clk;

    diag_sense_mux u0 (
        .clk(clk), .rst_n(rst_n), .sense_en(sense_en), .sense_sel(sense_sel),
        .cur_in(cur_in), .temp_in(temp_in), .vsup_in(vsup_in),
        .therm_evt(therm_evt), .hot_temp(hot_temp), .ch_on(ch_on),
        .open_load(open_load), .neg_out(neg_out),
        .sense_data(sense_data), .sense_drive(sense_drive)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(string req);
        checks++;
        if (int'(sense_drive) != exp_drive || int'(sense_data) != exp_data) begin
            fails++;
            $display("FAIL %s: drive=%0d data=%0h expected drive=%0d data=%0h",
                     req, sense_drive, sense_data, exp_drive, exp_data);
        end
    endtask

    // Reference model: one rising edge using the inputs held since the falling edge.
    task automatic model_edge();
        int c;
        int sc;
        if (!rst_n) begin
            exp_drive = 0; exp_data = 0; mflag[0] = 0; mflag[1] = 0;
            return;
        end
        if (!sense_en) begin
            exp_drive = 0; exp_data = 0;
        end else if (sense_sel == 2'd2) begin
            exp_drive = 1; exp_data = int'(temp_in);
        end else if (sense_sel == 2'd3) begin
            exp_drive = 1; exp_data = int'(vsup_in);
        end else begin
            c = int'(sense_sel);
            sc = int'(cur_in[c]) / (1 << KSH);
            if (sc >= ALL1) sc = ALL1 - 1;
            if (neg_out[c]) begin
                exp_drive = 0; exp_data = 0;
            end else if (therm_evt[c] || mflag[c] != 0 || (!ch_on[c] && open_load[c])) begin
                exp_drive = 1; exp_data = ALL1;
            end else begin
                exp_drive = 1; exp_data = sc;
            end
        end
        for (int k = 0; k < 2; k++)
            mflag[k] = (therm_evt[k] || (mflag[k] != 0 && int'(hot_temp[k]) >= CLR)) ? 1 : 0;
    endtask

    task automatic cyc(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc("R9");
        cyc("R9");
        rst_n = 1'b1;
        cur_in[0] = 16'h1234; cur_in[1] = 16'h0AB0;
        temp_in = 12'h3C5; vsup_in = 12'h7A1;
        hot_temp[0] = 8'd50; hot_temp[1] = 8'd50;
        // R1 enable low releases the line
        sense_en = 1'b0; cyc("R1");
        therm_evt = 2'b01; cyc("R1");
        therm_evt = 2'b00; hot_temp[0] = 8'd50; cyc("R1");
        // R2 select decode
        sense_en = 1'b1;
        sense_sel = 2'b00; cyc("R2");
        sense_sel = 2'b01; cyc("R2");
        sense_sel = 2'b10; cyc("R2");
        sense_sel = 2'b11; cyc("R2");
        // R3 scaling and clamp
        sense_sel = 2'b00; cur_in[0] = 16'hFFFF; cyc("R3");
        cur_in[0] = 16'hFFF0; cyc("R3");
        cur_in[0] = 16'h000F; cyc("R3");
        cur_in[0] = 16'h1234;
        // R4 thermal event on its own channel only
        hot_temp[0] = 8'd150; therm_evt = 2'b01; cyc("R4");
        sense_sel = 2'b01; cyc("R4");
        // R5 temperature and supply unaffected
        sense_sel = 2'b10; cyc("R5");
        sense_sel = 2'b11; cyc("R5");
        // R6 hysteresis walk-down
        therm_evt = 2'b00; sense_sel = 2'b00;
        hot_temp[0] = 8'd130; cyc("R6");
        hot_temp[0] = 8'd110; cyc("R6");
        hot_temp[0] = 8'd100; cyc("R6");
        hot_temp[0] = 8'd99;  cyc("R6");
        cyc("R6");
        cyc("R6");
        // R7 open load only when commanded off
        open_load = 2'b10; sense_sel = 2'b01; ch_on = 2'b11; cyc("R7");
        ch_on = 2'b01; cyc("R7");
        sense_sel = 2'b00; cyc("R7");
        open_load = 2'b00; ch_on = 2'b11;
        // R8 negative output releases, over fault
        neg_out = 2'b10; sense_sel = 2'b01; cyc("R8");
        therm_evt = 2'b10; hot_temp[1] = 8'd200; cyc("R8");
        sense_sel = 2'b00; cyc("R8");
        neg_out = 2'b00; therm_evt = 2'b00; hot_temp[1] = 8'd20;
        sense_sel = 2'b01; cyc("R6");
        cyc("R6");
        // R9 reset clears flags and outputs
        therm_evt = 2'b01; hot_temp[0] = 8'd180; sense_sel = 2'b00; cyc("R4");
        therm_evt = 2'b00; rst_n = 1'b0; cyc("R9");
        rst_n = 1'b1; cyc("R9");
        done = 1;
        summary();
        $finish;
    end
endmodule